// File: doc/BRIEF.md
# Flash Command Register and Embedded Erase Controller

This block is a device-side model of the command logic in a parallel NOR flash. It watches host write cycles (address, data and an active-low write strobe) and recognises multi-cycle command sequences. The sequences start with fixed unlock writes. It supports a return to array reads, reading the identification codes, erasing the whole array and erasing one sector. A small register array stands in for the memory cells, so the effect of each erase can be read back.

A command is accepted on the rising edge of the write strobe. An erase then runs on its own. It first writes zero to every word in its range, then waits a fixed number of clock cycles that stands in for the physical erase, then sets the range to all ones. While the erase runs, every read returns a status word and no array data. An error-injection input forces the time-out path, so that the failure status and the abort command can be exercised.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the block is in array-read mode and word i of the array reads 16'hA500 | i. A read pulse on rd_en gives its data on rdata in the following cycle.
- R2: Unlock writes are data AAh at address 555h, then data 55h at address 2AAh, compared on data bits [7:0] and address bits [10:0]. Any write that does not match the next step returns the block to array-read mode and has no effect on the array.
- R3: Chip erase is the six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. Once it completes, every array word reads FFFFh.
- R4: Sector erase is the same first five writes followed by 30h at any address. Address bits [3:2] of that write select the sector of four words. Only that sector reads FFFFh afterwards, and all other words keep their values.
- R5: The erase starts on the strobe edge of the confirming write, so the first read after it returns status. A sector erase ends 4 + ERASE_CYCLES clocks later and a chip erase ends 16 + ERASE_CYCLES clocks later. The block then returns to array-read mode.
- R6: While an erase runs or has failed, a read returns a status word. Bits [15:8] and bit 7 of that word are 0.
- R7: Status bit 6 inverts on each successive status read. It stops changing once array data is returned again.
- R8: If err_inject is 1 at the confirming write, status bit 5 reads 1 once TIMEOUT_CYCLES have elapsed after the zero-fill. The block stays failed until a write of F0h returns it to array-read mode.
- R9: AAh@555h, 55h@2AAh, 90h@555h enters identification mode. Reads with address bits [1:0] = 00 return 00C2h. Reads with 01 return 22B9h, or 22BAh when BOTTOM_BOOT is 1. Reads with any other value return 0000h.
- R10: Writes made while an erase runs are ignored, F0h and unlock writes included. The erase completes unchanged.
- R11: A write of F0h in array-read mode or within a sequence leaves or returns the block in array-read mode. In identification mode only F0h leaves that mode; every other write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Active-low write strobe; a write is taken on its rising edge |
| rd_en | input | 1 | One-cycle read request |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; commands use bits [7:0] |
| err_inject | input | 1 | Sampled at the confirming write; forces the erase time-out |
| rdata | output | DATA_W | Read data: array word, identification code or status |

## Verification
The reset pattern is read back word by word, and all four identification addresses are read. The bench then breaks a chip-erase sequence at each of its six positions and follows the break with the rest of the sequence. This separates a state machine that truly returns to idle from one that resynchronises on a later step. Sector erases at two sectors with random upper address bits compare the whole array against a model. This shows whether the sector decode, the zero-fill range and the final fill hit exactly four words. Writes during a busy erase, a chip erase and an injected time-out with its abort show whether busy, failed and done status are each reached and left at the right time.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 16,
  parameter int NUM_SECT       = 4,
  parameter int SECT_WORDS     = 4,
  parameter int ERASE_CYCLES   = 64,
  parameter int TIMEOUT_CYCLES = 100,
  parameter bit BOTTOM_BOOT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              err_inject,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH   = NUM_SECT * SECT_WORDS;
  localparam int MEM_AW  = $clog2(DEPTH);
  localparam int SW_AW   = $clog2(SECT_WORDS);
  localparam int SEC_AW  = MEM_AW - SW_AW;
  localparam int CNT_MAX = (ERASE_CYCLES > TIMEOUT_CYCLES) ? ERASE_CYCLES : TIMEOUT_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [15:0] MFR_CODE = 16'h00C2;
  localparam logic [15:0] DEV_CODE = BOTTOM_BOOT ? 16'h22BA : 16'h22B9;

  typedef enum logic [3:0] {
    S_READ, S_C1, S_C2, S_C3, S_C4, S_C5, S_ID, S_PRE, S_ERS, S_FAIL
  } st_t;

  st_t                state;
  logic               we_n_q;
  logic               chip_q, err_q, tog;
  logic [SEC_AW-1:0]  sec_q;
  logic [MEM_AW-1:0]  idx;
  logic [CNT_W-1:0]   cnt;
  logic [DATA_W-1:0]  mem [DEPTH];

  logic strobe, at555, at2aa, busy, failed, id_mode;
  logic [7:0] cmd;
  logic [MEM_AW-1:0] idx_last, zero_addr;

  assign strobe    = we_n & ~we_n_q;
  assign cmd       = wdata[7:0];
  assign at555     = addr[10:0] == 11'h555;
  assign at2aa     = addr[10:0] == 11'h2AA;
  assign busy      = (state == S_PRE) || (state == S_ERS);
  assign failed    = state == S_FAIL;
  assign id_mode   = state == S_ID;
  assign idx_last  = chip_q ? MEM_AW'(DEPTH - 1) : MEM_AW'(SECT_WORDS - 1);
  assign zero_addr = chip_q ? idx : {sec_q, idx[SW_AW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_READ;
      we_n_q <= 1'b1;
      chip_q <= 1'b0;
      err_q  <= 1'b0;
      sec_q  <= '0;
      idx    <= '0;
      cnt    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(16'hA500 | i);
    end else begin
      we_n_q <= we_n;
      case (state)
        S_READ: if (strobe && cmd == 8'hAA && at555) state <= S_C1;
        S_C1:   if (strobe) state <= (cmd == 8'h55 && at2aa) ? S_C2 : S_READ;
        S_C2:   if (strobe) begin
                  if (cmd == 8'h90 && at555)      state <= S_ID;
                  else if (cmd == 8'h80 && at555) state <= S_C3;
                  else                            state <= S_READ;
                end
        S_C3:   if (strobe) state <= (cmd == 8'hAA && at555) ? S_C4 : S_READ;
        S_C4:   if (strobe) state <= (cmd == 8'h55 && at2aa) ? S_C5 : S_READ;
        S_C5:   if (strobe) begin
                  idx   <= '0;
                  err_q <= err_inject;
                  sec_q <= addr[MEM_AW-1:SW_AW];
                  if (cmd == 8'h10 && at555) begin
                    chip_q <= 1'b1;
                    state  <= S_PRE;
                  end else if (cmd == 8'h30) begin
                    chip_q <= 1'b0;
                    state  <= S_PRE;
                  end else begin
                    state  <= S_READ;
                  end
                end
        S_ID:   if (strobe && cmd == 8'hF0) state <= S_READ;
        S_PRE:  begin
                  mem[zero_addr] <= '0;
                  idx <= idx + 1'b1;
                  if (idx == idx_last) begin
                    cnt   <= '0;
                    state <= S_ERS;
                  end
                end
        S_ERS:  begin
                  cnt <= cnt + 1'b1;
                  if (err_q && cnt == CNT_W'(TIMEOUT_CYCLES - 1)) begin
                    state <= S_FAIL;
                  end else if (!err_q && cnt == CNT_W'(ERASE_CYCLES - 1)) begin
                    for (int i = 0; i < DEPTH; i++)
                      if (chip_q || (i / SECT_WORDS) == int'(sec_q)) mem[i] <= '1;
                    state <= S_READ;
                  end
                end
        S_FAIL: if (strobe && cmd == 8'hF0) state <= S_READ;
        default: state <= S_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      tog   <= 1'b0;
    end else if (rd_en) begin
      if (busy || failed) begin
        rdata <= DATA_W'({1'b0, tog, failed, 5'b0});
        tog   <= ~tog;
      end else if (id_mode) begin
        case (addr[1:0])
          2'b00:   rdata <= DATA_W'(MFR_CODE);
          2'b01:   rdata <= DATA_W'(DEV_CODE);
          default: rdata <= '0;
        endcase
      end else begin
        rdata <= mem[addr[MEM_AW-1:0]];
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              we_n,
  input logic              rd_en,
  input logic [1:0]        addr_lo,
  input logic [7:0]        wdata_lo,
  input logic              busy,
  input logic              failed,
  input logic              id_mode,
  input logic [DATA_W-1:0] rdata
);
  logic we_q, stat_rd_q, have_prev, prev_b6, strobe;
  assign strobe = we_n & ~we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      stat_rd_q <= 1'b0;
      have_prev <= 1'b0;
      prev_b6   <= 1'b0;
    end else begin
      we_q      <= we_n;
      stat_rd_q <= rd_en && (busy || failed);
      if (stat_rd_q) begin
        have_prev <= 1'b1;
        prev_b6   <= rdata[6];
      end else if (!(busy || failed)) begin
        have_prev <= 1'b0;
      end
    end
  end

  // R6
  status_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (busy || failed) |=> rdata[7] == 1'b0 && rdata[DATA_W-1:8] == '0);

  // R7
  toggle_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_q && have_prev |-> rdata[6] != prev_b6);

  // R8
  fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && failed |=> rdata[5]);

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    failed && !(strobe && wdata_lo == 8'hF0) |=> failed);

  // R9
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && id_mode && addr_lo == 2'b00 |=> rdata == DATA_W'(16'h00C2));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .we_n(we_n), .rd_en(rd_en),
  .addr_lo(addr[1:0]), .wdata_lo(wdata[7:0]),
  .busy(busy), .failed(failed), .id_mode(id_mode), .rdata(rdata)
);

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int SW    = 4;
  localparam int ERASE = 64;
  localparam int TOUT  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_n = 1'b1;
  logic rd_en = 1'b0;
  logic err_inject = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int tests = 0;
  int fails = 0;
  bit done_flag = 1'b0;
  logic [15:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_fsm u_flash_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .err_inject(err_inject), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hA500 | 16'(i);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk) begin addr = a; wdata = {8'h00, d}; we_n = 1'b0; end
    @(negedge clk) we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk) begin addr = a; rd_en = 1'b1; end
    @(negedge clk) rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic pre5();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  task automatic check_array(input string req);
    logic [15:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(12'(i), v);
      chk(v == model[i], req, v, model[i]);
    end
  endtask

  task automatic wait_done(input logic [11:0] a, input int limit, input string req);
    logic [15:0] v;
    int n = 0;
    v = 16'h0000;
    while (v[7] == 1'b0 && n < limit) begin
      rd(a, v);
      n += 2;
    end
    chk(v == 16'hFFFF, req, v, 16'hFFFF);
  endtask

  initial begin
    logic [15:0] v, v2;
    logic [11:0] seq_a [6];
    logic [7:0]  seq_d [6];
    seq_a = '{12'h555, 12'h2AA, 12'h555, 12'h555, 12'h2AA, 12'h555};
    seq_d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};

    do_reset();
    check_array("R1");

    // R9 identification codes, R11 non-F0 writes ignored in ID mode
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    rd(12'h000, v); chk(v == 16'h00C2, "R9", v, 16'h00C2);
    rd(12'h001, v); chk(v == 16'h22B9, "R9", v, 16'h22B9);
    rd(12'h002, v); chk(v == 16'h0000, "R9", v, 16'h0000);
    rd(12'h7F3, v); chk(v == 16'h0000, "R9", v, 16'h0000);
    wr(12'h555, 8'hAA);
    rd(12'h004, v); chk(v == 16'h00C2, "R11", v, 16'h00C2);
    wr(12'h000, 8'hF0);
    rd(12'h004, v); chk(v == model[4], "R11", v, model[4]);
    wr(12'h123, 8'hF0);
    rd(12'h005, v); chk(v == model[5], "R11", v, model[5]);

    // R2 break the chip-erase sequence at every position
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < k; j++) wr(seq_a[j], seq_d[j]);
      wr(12'h123, 8'h77);
      for (int j = k + 1; j < 6; j++) wr(seq_a[j], seq_d[j]);
      rd(12'(k), v); chk(v == model[k], "R2", v, model[k]);
    end
    check_array("R2");

    // R4/R5/R6/R7 sector erase of sector 1 with busy status checks
    pre5();
    wr(12'hA05, 8'h30);
    rd(12'h004, v);
    chk(v[7] == 1'b0 && v[15:8] == 8'h00, "R5", v, 16'h0000);
    rd(12'h004, v2);
    chk(v2[6] == ~v[6], "R7", v2, {v[15:7], ~v[6], v[5:0]});
    rd(12'h004, v);
    chk(v[6] == ~v2[6] && v[5] == 1'b0, "R6", v, {v2[15:7], ~v2[6], 6'b0});
    wait_done(12'h004, SW + ERASE + 8, "R5");
    for (int i = 4; i < 8; i++) model[i] = 16'hFFFF;
    check_array("R4");
    rd(12'h004, v); rd(12'h004, v2);
    chk(v == v2, "R7", v2, v);

    // R4/R10 sector 3 erase; writes while busy are ignored
    pre5();
    wr(12'h30C, 8'h30);
    wr(12'h000, 8'hF0);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h90);
    wait_done(12'h00C, SW + ERASE + 8, "R10");
    for (int i = 12; i < 16; i++) model[i] = 16'hFFFF;
    check_array("R10");

    // R3 chip erase
    do_reset();
    for (int j = 0; j < 6; j++) wr(seq_a[j], seq_d[j]);
    rd(12'h000, v); chk(v[7] == 1'b0, "R3", v, 16'h0000);
    wait_done(12'h000, DEPTH + ERASE + 8, "R3");
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    check_array("R3");

    // R8 injected time-out and abort
    do_reset();
    pre5();
    err_inject = 1'b1;
    wr(12'h008, 8'h30);
    err_inject = 1'b0;
    rd(12'h000, v); chk(v[5] == 1'b0 && v[7] == 1'b0, "R8", v, 16'h0000);
    repeat (SW + TOUT + 4) @(negedge clk);
    rd(12'h000, v); chk(v[5] == 1'b1 && v[7] == 1'b0, "R8", v, 16'h0020);
    rd(12'h000, v2); chk(v2[6] == ~v[6], "R7", v2, {v[15:7], ~v[6], v[5:0]});
    wr(12'h555, 8'hAA);
    rd(12'h000, v); chk(v[5] == 1'b1, "R8", v, 16'h0020);
    wr(12'h000, 8'hF0);
    rd(12'h001, v); chk(v == model[1], "R8", v, model[1]);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule